// File: doc/BRIEF.md
# Power-Management Event Controller

This block gathers power-management events for a chip: a free-running timer whose half-range crossings raise an overflow event, a power-button input and a real-time-clock input. Each event sets a sticky status bit. A matching enable bit decides whether that status bit drives the level-sensitive system control interrupt (`sci`). Software reads the timer and the status, enable and control registers over a simple register bus. It clears status bits by writing ones to them.

A separate two-byte port carries power-management commands from the firmware. A write to its command byte can pulse a system-management request, and two command codes switch the interrupt-routing bit of the control register on and off. A write to the control register that has the suspend-enable bit set and a sleep type of zero pulses a soft-power-off request.

The timer advances once per clock cycle in which `tmr_tick` is high. `tmr_tick` is a clock enable at the nominal timer rate.

Top module: `pm_event_ctrl`

## Requirements
- R1: The timer is TMR_W bits wide. It increments by one, with wrap-around, on each cycle where `tmr_tick` is high, and holds otherwise. A read at offset 0x08 returns the timer zero-extended to 32 bits.
- R2: A read at offset 0x00 returns the 16-bit status register, at 0x02 the 16-bit enable register, and at 0x04 the 16-bit control register, each zero-extended. A read at any other offset returns zero. A write to any other offset changes no register.
- R3: A write to offset 0x00 clears each status bit whose data bit is 1 and leaves each status bit whose data bit is 0 unchanged.
- R4: Status bit 0 (timer overflow) sets on every tick that carries the timer across a multiple of 2^(TMR_W-1), that is, on every toggle of its top bit.
- R5: A rising edge on `pwrbtn_evt` sets status bit 8. A rising edge on `rtc_evt` sets status bit 10. A level held high does not set the bit again after it is cleared.
- R6: `sci` is high exactly while one of status bits 0, 5, 8 or 10 is set together with the same bit of the enable register.
- R7: Control bit 13 (suspend enable) is never stored and always reads 0. A control write with bit 13 = 1 and bits 11:10 = 0 makes `poweroff_req` high for exactly the one cycle that follows the write. Any other control write leaves `poweroff_req` low.
- R8: On the APM port, `apm_sel` = 0 selects the command byte and `apm_sel` = 1 selects the status byte. `apm_rdata` returns the last value written to the selected byte.
- R9: Writing 0xF1 to the command byte sets control bit 0. Writing 0xF0 clears it. Other command values leave the control register unchanged.
- R10: A command-byte write makes `smi_req` high for the one following cycle only if `smi_cfg_en` is high. Writes to the status byte never raise `smi_req`.
- R11: Reset clears the timer and all registers, and holds every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_tick | input | 1 | Timer clock enable |
| reg_wr | input | 1 | Register bus write strobe |
| reg_addr | input | ADDR_W | Register bus byte offset |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Register bus read data (combinational on `reg_addr`) |
| apm_wr | input | 1 | APM port write strobe |
| apm_sel | input | 1 | APM byte select: 0 command, 1 status |
| apm_wdata | input | 8 | APM port write data |
| apm_rdata | output | 8 | APM port read data |
| smi_cfg_en | input | 1 | Enables system-management requests |
| pwrbtn_evt | input | 1 | Power-button event (synchronous) |
| rtc_evt | input | 1 | Real-time-clock event (synchronous) |
| sci | output | 1 | Level system control interrupt |
| smi_req | output | 1 | One-cycle system-management request |
| poweroff_req | output | 1 | One-cycle soft-power-off request |

## Verification
The bench builds the block with TMR_W = 8, so the overflow boundary sits at 128 ticks instead of 2^23. Both the mid-range crossing and the full wrap back to zero can then be reached in a few hundred cycles. ADDR_W keeps its default of 6, so unmapped offsets such as 0x06 and 0x0C are reachable. With these values, the same run also covers the status-clear interplay with held event levels, every branch of the sleep-type decode, and the command-code side effects.

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl #(
  parameter int TMR_W  = 24,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              apm_wr,
  input  logic              apm_sel,
  input  logic [7:0]        apm_wdata,
  output logic [7:0]        apm_rdata,
  input  logic              smi_cfg_en,
  input  logic              pwrbtn_evt,
  input  logic              rtc_evt,
  output logic              sci,
  output logic              smi_req,
  output logic              poweroff_req
);

  localparam logic [ADDR_W-1:0] OFS_STS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_EN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_TMR = ADDR_W'(8);
  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;
  localparam int B_SUS = 13;
  localparam logic [15:0] SCI_MASK = 16'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWR) | (1 << B_RTC));
  localparam logic [7:0] CMD_ON  = 8'hF1;
  localparam logic [7:0] CMD_OFF = 8'hF0;

  logic [TMR_W-1:0] timer_q;
  logic [15:0] sts_q, en_q, ctl_q, sts_nx, ctl_nx, sts_set;
  logic [7:0]  cmd_q, apst_q;
  logic        pb_q, rtc_q, smi_q, off_q;

  wire wr_sts   = reg_wr && (reg_addr == OFS_STS);
  wire wr_en    = reg_wr && (reg_addr == OFS_EN);
  wire wr_ctl   = reg_wr && (reg_addr == OFS_CTL);
  wire wr_cmd   = apm_wr && !apm_sel;
  wire tmr_wrap = tmr_tick && (&timer_q[TMR_W-2:0]);
  wire pb_rise  = pwrbtn_evt && !pb_q;
  wire rtc_rise = rtc_evt && !rtc_q;
  wire off_hit  = wr_ctl && reg_wdata[B_SUS] && (reg_wdata[11:10] == 2'b00);

  always_comb begin
    sts_set = '0;
    sts_set[B_TMR] = tmr_wrap;
    sts_set[B_PWR] = pb_rise;
    sts_set[B_RTC] = rtc_rise;
    sts_nx = (sts_q & ~(wr_sts ? reg_wdata[15:0] : 16'h0)) | sts_set;
  end

  always_comb begin
    ctl_nx = ctl_q;
    if (wr_ctl) begin
      ctl_nx = reg_wdata[15:0];
      ctl_nx[B_SUS] = 1'b0;
    end
    if (wr_cmd && apm_wdata == CMD_ON)  ctl_nx[0] = 1'b1;
    if (wr_cmd && apm_wdata == CMD_OFF) ctl_nx[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q <= '0;
      sts_q   <= '0;
      en_q    <= '0;
      ctl_q   <= '0;
      cmd_q   <= '0;
      apst_q  <= '0;
      pb_q    <= 1'b0;
      rtc_q   <= 1'b0;
      smi_q   <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      if (tmr_tick) timer_q <= timer_q + TMR_W'(1);
      sts_q <= sts_nx;
      if (wr_en) en_q <= reg_wdata[15:0];
      ctl_q <= ctl_nx;
      if (wr_cmd) cmd_q <= apm_wdata;
      if (apm_wr && apm_sel) apst_q <= apm_wdata;
      pb_q  <= pwrbtn_evt;
      rtc_q <= rtc_evt;
      smi_q <= wr_cmd && smi_cfg_en;
      off_q <= off_hit;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STS: reg_rdata = {16'h0, sts_q};
      OFS_EN:  reg_rdata = {16'h0, en_q};
      OFS_CTL: reg_rdata = {16'h0, ctl_q};
      OFS_TMR: reg_rdata = 32'(timer_q);
      default: reg_rdata = 32'h0;
    endcase
  end

  assign apm_rdata    = apm_sel ? apst_q : cmd_q;
  assign sci          = |(sts_q & en_q & SCI_MASK);
  assign smi_req      = smi_q;
  assign poweroff_req = off_q;

  // R1: timer steps by one on each tick
  a_r1_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> timer_q == $past(timer_q) + TMR_W'(1));

  // R4: a half-range crossing leaves the overflow status set
  a_r4_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_tick && (&timer_q[TMR_W-2:0])) |=> sts_q[B_TMR]);

  // R5: a power-button rising edge is recorded
  a_r5_pwrbtn_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrbtn_evt) |=> sts_q[B_PWR]);

  // R7: suspend enable never reads back
  a_r7_sus_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == OFS_CTL |-> !reg_rdata[B_SUS]);

  // R7: power-off pulse only after a type-0 suspend write
  a_r7_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_req |-> $past(reg_wr && reg_addr == OFS_CTL && reg_wdata[B_SUS] && reg_wdata[11:10] == 2'b00));

  // R9: the enable code sets control bit 0
  a_r9_cmd_on: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !apm_sel && apm_wdata == CMD_ON) |=> ctl_q[0]);

  // R10: a system-management request needs the gate and a command write
  a_r10_smi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(apm_wr && !apm_sel && smi_cfg_en));

endmodule

// File: tb/sim_pm_event_ctrl.sv
module sim_pm_event_ctrl;
  localparam int TMR_W = 8;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_tick = 1'b0, reg_wr = 1'b0, apm_wr = 1'b0, apm_sel = 1'b0;
  logic smi_cfg_en = 1'b0, pwrbtn_evt = 1'b0, rtc_evt = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] apm_wdata = '0, apm_rdata;
  logic sci, smi_req, poweroff_req;

  pm_event_ctrl #(.TMR_W(TMR_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .apm_wr(apm_wr), .apm_sel(apm_sel), .apm_wdata(apm_wdata), .apm_rdata(apm_rdata),
    .smi_cfg_en(smi_cfg_en), .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt),
    .sci(sci), .smi_req(smi_req), .poweroff_req(poweroff_req));

  always #5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {24'h0, apm_rdata};
        2: act = {31'h0, sci};
        3: act = {31'h0, smi_req};
        default: act = {31'h0, poweroff_req};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic expect_now(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    step();
  endtask

  task automatic chk_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    expect_now(0, e, tag);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic apm(input logic sel, input logic [7:0] d);
    apm_sel = sel; apm_wdata = d; apm_wr = 1'b1;
    step();
    apm_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tmr_tick = 1'b1;
    repeat (n) step();
    tmr_tick = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R11 reset state
    chk_rd(6'h00, 32'h0, "R11 status after reset");
    chk_rd(6'h08, 32'h0, "R11 timer after reset");
    chk_rd(6'h04, 32'h0, "R11 control after reset");
    expect_now(2, 0, "R11 sci low");
    expect_now(3, 0, "R11 smi low");
    expect_now(4, 0, "R11 poweroff low");
    apm_sel = 1'b0;
    expect_now(1, 0, "R11 apm command after reset");

    // R1 timer counts ticks only
    ticks(10);
    chk_rd(6'h08, 32'd10, "R1 timer after 10 ticks");
    step(); step();
    chk_rd(6'h08, 32'd10, "R1 timer holds without tick");

    // R4 overflow at half range
    ticks(117);
    chk_rd(6'h08, 32'd127, "R1 timer at 127");
    chk_rd(6'h00, 32'h0, "R4 no overflow before boundary");
    ticks(1);
    chk_rd(6'h08, 32'd128, "R1 timer at 128");
    chk_rd(6'h00, 32'h1, "R4 overflow at boundary");

    // R6 sci gated by enable, R3 write-one-to-clear
    expect_now(2, 0, "R6 sci low with enable clear");
    wr(6'h02, 32'h0001);
    chk_rd(6'h02, 32'h0001, "R2 enable readback");
    expect_now(2, 1, "R6 sci on overflow");
    wr(6'h00, 32'hFFFE);
    chk_rd(6'h00, 32'h1, "R3 zero bits leave status");
    wr(6'h00, 32'h0001);
    chk_rd(6'h00, 32'h0, "R3 one clears status");
    expect_now(2, 0, "R6 sci low after clear");

    // R4 wrap to zero also crosses
    ticks(128);
    chk_rd(6'h08, 32'd0, "R1 timer wrapped");
    chk_rd(6'h00, 32'h1, "R4 overflow at wrap");
    wr(6'h00, 32'h0001);

    // R5 event edges
    pwrbtn_evt = 1'b1;
    step();
    chk_rd(6'h00, 32'h0100, "R5 power button sets bit 8");
    expect_now(2, 0, "R6 sci low bit 8 not enabled");
    wr(6'h02, 32'h0500);
    expect_now(2, 1, "R6 sci on power button");
    wr(6'h00, 32'h0100);
    step();
    chk_rd(6'h00, 32'h0, "R5 held level does not reset bit");
    rtc_evt = 1'b1;
    step();
    chk_rd(6'h00, 32'h0400, "R5 rtc sets bit 10");
    expect_now(2, 1, "R6 sci on rtc");
    pwrbtn_evt = 1'b0; rtc_evt = 1'b0;
    wr(6'h00, 32'hFFFF);
    expect_now(2, 0, "R6 sci low after clear all");

    // R2 unmapped offsets
    chk_rd(6'h06, 32'h0, "R2 offset 0x06 reads zero");
    chk_rd(6'h0C, 32'h0, "R2 offset 0x0C reads zero");
    wr(6'h06, 32'hFFFF);
    chk_rd(6'h02, 32'h0500, "R2 unmapped write ignored");

    // R7 control and suspend
    wr(6'h04, 32'h2000);
    expect_now(4, 1, "R7 poweroff pulse on type 0");
    expect_now(4, 0, "R7 poweroff is one cycle");
    chk_rd(6'h04, 32'h0, "R7 suspend bit not stored");
    wr(6'h04, 32'h2C02);
    expect_now(4, 0, "R7 no poweroff for type 3");
    chk_rd(6'h04, 32'h0C02, "R7 control stored without bit 13");
    wr(6'h04, 32'h0000);
    expect_now(4, 0, "R7 no poweroff without suspend");

    // R9 command codes, R10 smi gating
    smi_cfg_en = 1'b1;
    apm(1'b0, 8'hF1);
    expect_now(3, 1, "R10 smi on command write");
    expect_now(3, 0, "R10 smi one cycle");
    chk_rd(6'h04, 32'h0001, "R9 F1 sets control bit 0");
    apm(1'b0, 8'h55);
    chk_rd(6'h04, 32'h0001, "R9 other code no effect");
    smi_cfg_en = 1'b0;
    apm(1'b0, 8'hF0);
    expect_now(3, 0, "R10 no smi when gate low");
    chk_rd(6'h04, 32'h0000, "R9 F0 clears control bit 0");
    smi_cfg_en = 1'b1;
    apm(1'b1, 8'hA5);
    expect_now(3, 0, "R10 no smi on status write");

    // R8 readback
    apm_sel = 1'b0;
    expect_now(1, 32'hF0, "R8 command readback");
    apm_sel = 1'b1;
    expect_now(1, 32'hA5, "R8 status readback");

    step();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule